// File: doc/BRIEF.md
# Fetch-and-Add Reply Decombining Buffer

This block sits on the return path of a two-port combining switch. When the forward path merges two fetch-and-add requests that target one address, it writes a record into this buffer. The record holds the merged request's tag, the tag and return port of each original requester, and the addend of the request serialized first. The merged request goes on to memory carrying the summed addend. A plain load is a fetch-and-add with addend zero and is handled the same way.

When the memory reply for a merged request comes back, the block searches its records by tag. On a hit it splits the single returned old value `v` into two replies. The first requester receives `v`. The second receives `v` plus the stored first addend, modulo 2^32. Together they match one serial order of the two operations. The entry is freed once both replies have been accepted downstream. A reply whose tag matches no record is forwarded unchanged to the port it names. The block raises `full_o` when no entry is free, so that the forward path sends requests individually instead of combining them.

Top module: `faa_decomb_buf`

## Requirements
- R1: After reset `full_o` is 0, both `out_valid_o` bits are 0 and `rsp_ready_o` is 1.
- R2: An accepted allocation (`alloc_valid_i` high while `full_o` is 0) takes one free entry at the clock edge. `full_o` goes to 1 in the cycle after the allocation that fills the last of the 16 entries.
- R3: An allocation presented while `full_o` is 1 stores nothing, so a later reply carrying that tag is passed through.
- R4: A reply accepted with a tag that matches a record produces two replies. The first carries the record's first tag, goes to its first port and holds the returned value `v`. The second carries the second tag, goes to its second port and holds `v` plus the stored addend. An addend of 0 returns `v` to both requesters.
- R5: The value for the second requester wraps modulo 2^32.
- R6: A reply accepted with a tag that matches no record is emitted once, on output `rsp_port_i` (0 or 1), with tag `rsp_tag_i` and its value unchanged.
- R7: When both requesters share an output port and that port is ready, the first reply is valid in the cycle after the reply is accepted and the second reply is valid in the cycle after that.
- R8: When the two requesters use different output ports, both replies are valid in the same cycle, the cycle after the reply is accepted.
- R9: A valid output that is not accepted holds its valid, tag and data. `rsp_ready_o` stays 0 until every pending split reply has been accepted.
- R10: The entry is freed at the edge where its last reply is accepted. `full_o` falls in the next cycle, and a later reply with the same tag passes through.
- R11: An allocation and a reply lookup may be accepted in the same cycle, and both take effect.
- R12: An entry freed at one edge can be allocated again at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| alloc_valid_i | input | 1 | Write a combining record |
| alloc_id_i | input | TAG_W | Tag of the merged request |
| alloc_tag_first_i | input | TAG_W | Tag of the requester serialized first |
| alloc_port_first_i | input | PORT_W | Return port of the first requester |
| alloc_tag_second_i | input | TAG_W | Tag of the second requester |
| alloc_port_second_i | input | PORT_W | Return port of the second requester |
| alloc_addend_i | input | DATA_W | Addend of the first requester |
| full_o | output | 1 | No free entry; forward path must not combine |
| rsp_valid_i | input | 1 | Reply from memory side valid |
| rsp_ready_o | output | 1 | Reply accepted this cycle when valid |
| rsp_tag_i | input | TAG_W | Reply tag |
| rsp_port_i | input | PORT_W | Output port for a reply that passes through |
| rsp_data_i | input | DATA_W | Returned old value |
| out_valid_o | output | 2 | Per-port reply valid |
| out_ready_i | input | 2 | Per-port downstream ready |
| out_tag_o | output | 2 x TAG_W | Per-port reply tag |
| out_data_o | output | 2 x DATA_W | Per-port reply value |

## Verification
A corrupted record shows up as a wrong tag or value on an output port in the cycle after the matching reply is accepted. A lost record shows up as a pass-through on the reply's own port instead of two replies. A leaked entry, one freed too late or never, keeps `full_o` high or leaves the tag matching after both replies have gone. That becomes visible one cycle after the final handshake. A broken hold under backpressure changes the held tag or data on the next edge.

// File: rtl/faa_decomb_pkg.sv
package faa_decomb_pkg;
  localparam int NUM_OUT = 2;
  localparam int PORT_W  = 1;

  typedef enum logic [1:0] {
    SEL_NONE   = 2'd0,
    SEL_FIRST  = 2'd1,
    SEL_SECOND = 2'd2
  } out_sel_e;
endpackage

// File: rtl/faa_free_finder.sv
module faa_free_finder #(
  parameter int N_ENTRIES = 16
) (
  input  logic [N_ENTRIES-1:0] valid_i,
  output logic [N_ENTRIES-1:0] free_oh_o,
  output logic                 full_o
);
  // lowest free index wins
  logic [N_ENTRIES:0] taken;
  assign taken[0] = 1'b0;
  for (genvar i = 0; i < N_ENTRIES; i++) begin : g_pick
    assign free_oh_o[i] = !valid_i[i] && !taken[i];
    assign taken[i+1]   = taken[i] || !valid_i[i];
  end
  assign full_o = &valid_i;
endmodule

// File: rtl/faa_record_table.sv
module faa_record_table #(
  parameter int N_ENTRIES = 16,
  parameter int TAG_W     = 8,
  parameter int DATA_W    = 32,
  parameter int PORT_W    = 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_en_i,
  input  logic [N_ENTRIES-1:0] wr_oh_i,
  input  logic [TAG_W-1:0]     wr_id_i,
  input  logic [TAG_W-1:0]     wr_tag_a_i,
  input  logic [PORT_W-1:0]    wr_port_a_i,
  input  logic [TAG_W-1:0]     wr_tag_b_i,
  input  logic [PORT_W-1:0]    wr_port_b_i,
  input  logic [DATA_W-1:0]    wr_addend_i,
  input  logic                 clr_en_i,
  input  logic [N_ENTRIES-1:0] clr_oh_i,
  input  logic [TAG_W-1:0]     look_id_i,
  output logic                 hit_o,
  output logic [N_ENTRIES-1:0] hit_oh_o,
  output logic [TAG_W-1:0]     hit_tag_a_o,
  output logic [PORT_W-1:0]    hit_port_a_o,
  output logic [TAG_W-1:0]     hit_tag_b_o,
  output logic [PORT_W-1:0]    hit_port_b_o,
  output logic [DATA_W-1:0]    hit_addend_o,
  output logic [N_ENTRIES-1:0] valid_o
);
  logic [N_ENTRIES-1:0] valid_q;
  logic [TAG_W-1:0]     id_q     [N_ENTRIES];
  logic [TAG_W-1:0]     tag_a_q  [N_ENTRIES];
  logic [PORT_W-1:0]    port_a_q [N_ENTRIES];
  logic [TAG_W-1:0]     tag_b_q  [N_ENTRIES];
  logic [PORT_W-1:0]    port_b_q [N_ENTRIES];
  logic [DATA_W-1:0]    add_q    [N_ENTRIES];

  for (genvar i = 0; i < N_ENTRIES; i++) begin : g_ent
    logic set_w, clr_w;
    assign set_w = wr_en_i && wr_oh_i[i];
    assign clr_w = clr_en_i && clr_oh_i[i];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) valid_q[i] <= 1'b0;
      else if (set_w) valid_q[i] <= 1'b1;
      else if (clr_w) valid_q[i] <= 1'b0;
    end

    always_ff @(posedge clk_i) begin
      if (set_w) begin
        id_q[i]     <= wr_id_i;
        tag_a_q[i]  <= wr_tag_a_i;
        port_a_q[i] <= wr_port_a_i;
        tag_b_q[i]  <= wr_tag_b_i;
        port_b_q[i] <= wr_port_b_i;
        add_q[i]    <= wr_addend_i;
      end
    end

    assign hit_oh_o[i] = valid_q[i] && (id_q[i] == look_id_i);
  end

  always_comb begin
    hit_tag_a_o  = '0;
    hit_port_a_o = '0;
    hit_tag_b_o  = '0;
    hit_port_b_o = '0;
    hit_addend_o = '0;
    for (int i = 0; i < N_ENTRIES; i++) begin
      if (hit_oh_o[i]) begin
        hit_tag_a_o  |= tag_a_q[i];
        hit_port_a_o |= port_a_q[i];
        hit_tag_b_o  |= tag_b_q[i];
        hit_port_b_o |= port_b_q[i];
        hit_addend_o |= add_q[i];
      end
    end
  end

  assign hit_o   = |hit_oh_o;
  assign valid_o = valid_q;
endmodule

// File: rtl/faa_split_stage.sv
module faa_split_stage
  import faa_decomb_pkg::*;
#(
  parameter int N_ENTRIES = 16,
  parameter int TAG_W     = 8,
  parameter int DATA_W    = 32
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 load_i,
  input  logic                 hit_i,
  input  logic [N_ENTRIES-1:0] hit_oh_i,
  input  logic [TAG_W-1:0]     rsp_tag_i,
  input  logic [PORT_W-1:0]    rsp_port_i,
  input  logic [DATA_W-1:0]    rsp_data_i,
  input  logic [TAG_W-1:0]     tag_a_i,
  input  logic [PORT_W-1:0]    port_a_i,
  input  logic [TAG_W-1:0]     tag_b_i,
  input  logic [PORT_W-1:0]    port_b_i,
  input  logic [DATA_W-1:0]    addend_i,
  output logic                 busy_o,
  output logic                 free_o,
  output logic [N_ENTRIES-1:0] free_oh_o,
  output logic [NUM_OUT-1:0]   out_valid_o,
  input  logic [NUM_OUT-1:0]   out_ready_i,
  output logic [NUM_OUT-1:0][TAG_W-1:0]  out_tag_o,
  output logic [NUM_OUT-1:0][DATA_W-1:0] out_data_o
);
  logic                 a_vld_q, b_vld_q, own_q;
  logic [TAG_W-1:0]     a_tag_q, b_tag_q;
  logic [PORT_W-1:0]    a_port_q, b_port_q;
  logic [DATA_W-1:0]    a_data_q, b_data_q;
  logic [N_ENTRIES-1:0] own_oh_q;
  logic                 a_take, b_take, b_blocked;
  out_sel_e             sel [NUM_OUT];

  // second reply waits behind the first on a shared port
  assign b_blocked = a_vld_q && (a_port_q == b_port_q);
  assign a_take    = a_vld_q && out_ready_i[a_port_q];
  assign b_take    = b_vld_q && !b_blocked && out_ready_i[b_port_q];

  for (genvar p = 0; p < NUM_OUT; p++) begin : g_out
    always_comb begin
      if (a_vld_q && a_port_q == PORT_W'(p))                     sel[p] = SEL_FIRST;
      else if (b_vld_q && !b_blocked && b_port_q == PORT_W'(p))  sel[p] = SEL_SECOND;
      else                                                       sel[p] = SEL_NONE;
    end
    assign out_valid_o[p] = (sel[p] != SEL_NONE);
    assign out_tag_o[p]   = (sel[p] == SEL_SECOND) ? b_tag_q  : a_tag_q;
    assign out_data_o[p]  = (sel[p] == SEL_SECOND) ? b_data_q : a_data_q;
  end

  assign busy_o    = a_vld_q || b_vld_q;
  assign free_o    = own_q && busy_o && (!a_vld_q || a_take) && (!b_vld_q || b_take);
  assign free_oh_o = own_oh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_vld_q <= 1'b0;
      b_vld_q <= 1'b0;
      own_q   <= 1'b0;
    end else if (load_i) begin
      a_vld_q <= 1'b1;
      b_vld_q <= hit_i;
      own_q   <= hit_i;
    end else begin
      if (a_take) a_vld_q <= 1'b0;
      if (b_take) b_vld_q <= 1'b0;
      if (free_o) own_q   <= 1'b0;
    end
  end

  always_ff @(posedge clk_i) begin
    if (load_i) begin
      a_tag_q  <= hit_i ? tag_a_i  : rsp_tag_i;
      a_port_q <= hit_i ? port_a_i : rsp_port_i;
      a_data_q <= rsp_data_i;
      b_tag_q  <= tag_b_i;
      b_port_q <= port_b_i;
      b_data_q <= rsp_data_i + addend_i;
      own_oh_q <= hit_oh_i;
    end
  end
endmodule

// File: rtl/faa_decomb_buf.sv
module faa_decomb_buf
  import faa_decomb_pkg::*;
#(
  parameter int N_ENTRIES = 16,
  parameter int TAG_W     = 8,
  parameter int DATA_W    = 32
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           alloc_valid_i,
  input  logic [TAG_W-1:0]               alloc_id_i,
  input  logic [TAG_W-1:0]               alloc_tag_first_i,
  input  logic [PORT_W-1:0]              alloc_port_first_i,
  input  logic [TAG_W-1:0]               alloc_tag_second_i,
  input  logic [PORT_W-1:0]              alloc_port_second_i,
  input  logic [DATA_W-1:0]              alloc_addend_i,
  output logic                           full_o,
  input  logic                           rsp_valid_i,
  output logic                           rsp_ready_o,
  input  logic [TAG_W-1:0]               rsp_tag_i,
  input  logic [PORT_W-1:0]              rsp_port_i,
  input  logic [DATA_W-1:0]              rsp_data_i,
  output logic [NUM_OUT-1:0]             out_valid_o,
  input  logic [NUM_OUT-1:0]             out_ready_i,
  output logic [NUM_OUT-1:0][TAG_W-1:0]  out_tag_o,
  output logic [NUM_OUT-1:0][DATA_W-1:0] out_data_o
);
  logic [N_ENTRIES-1:0] valid_vec, alloc_oh, lookup_oh, free_oh;
  logic                 lookup_hit, free_fire, stage_busy, alloc_fire, rsp_fire;
  logic [TAG_W-1:0]     h_tag_a, h_tag_b;
  logic [PORT_W-1:0]    h_port_a, h_port_b;
  logic [DATA_W-1:0]    h_addend;

  assign alloc_fire  = alloc_valid_i && !full_o;
  assign rsp_ready_o = !stage_busy;
  assign rsp_fire    = rsp_valid_i && rsp_ready_o;

  faa_free_finder #(.N_ENTRIES(N_ENTRIES)) u_free (
    .valid_i   (valid_vec),
    .free_oh_o (alloc_oh),
    .full_o    (full_o)
  );

  faa_record_table #(
    .N_ENTRIES(N_ENTRIES), .TAG_W(TAG_W), .DATA_W(DATA_W), .PORT_W(PORT_W)
  ) u_table (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_en_i      (alloc_fire),
    .wr_oh_i      (alloc_oh),
    .wr_id_i      (alloc_id_i),
    .wr_tag_a_i   (alloc_tag_first_i),
    .wr_port_a_i  (alloc_port_first_i),
    .wr_tag_b_i   (alloc_tag_second_i),
    .wr_port_b_i  (alloc_port_second_i),
    .wr_addend_i  (alloc_addend_i),
    .clr_en_i     (free_fire),
    .clr_oh_i     (free_oh),
    .look_id_i    (rsp_tag_i),
    .hit_o        (lookup_hit),
    .hit_oh_o     (lookup_oh),
    .hit_tag_a_o  (h_tag_a),
    .hit_port_a_o (h_port_a),
    .hit_tag_b_o  (h_tag_b),
    .hit_port_b_o (h_port_b),
    .hit_addend_o (h_addend),
    .valid_o      (valid_vec)
  );

  faa_split_stage #(
    .N_ENTRIES(N_ENTRIES), .TAG_W(TAG_W), .DATA_W(DATA_W)
  ) u_split (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (rsp_fire),
    .hit_i       (lookup_hit),
    .hit_oh_i    (lookup_oh),
    .rsp_tag_i   (rsp_tag_i),
    .rsp_port_i  (rsp_port_i),
    .rsp_data_i  (rsp_data_i),
    .tag_a_i     (h_tag_a),
    .port_a_i    (h_port_a),
    .tag_b_i     (h_tag_b),
    .port_b_i    (h_port_b),
    .addend_i    (h_addend),
    .busy_o      (stage_busy),
    .free_o      (free_fire),
    .free_oh_o   (free_oh),
    .out_valid_o (out_valid_o),
    .out_ready_i (out_ready_i),
    .out_tag_o   (out_tag_o),
    .out_data_o  (out_data_o)
  );
endmodule

// File: rtl/faa_decomb_buf_chk.sv
module faa_decomb_buf_chk
  import faa_decomb_pkg::*;
#(
  parameter int N_ENTRIES = 16,
  parameter int TAG_W     = 8,
  parameter int DATA_W    = 32
) (
  input logic                           clk_i,
  input logic                           rst_ni,
  input logic                           alloc_valid_i,
  input logic                           full_o,
  input logic                           rsp_valid_i,
  input logic                           rsp_ready_o,
  input logic [NUM_OUT-1:0]             out_valid_o,
  input logic [NUM_OUT-1:0]             out_ready_i,
  input logic [NUM_OUT-1:0][TAG_W-1:0]  out_tag_o,
  input logic [NUM_OUT-1:0][DATA_W-1:0] out_data_o,
  input logic                           lookup_hit,
  input logic [N_ENTRIES-1:0]           lookup_oh,
  input logic                           free_fire
);
  assert_full_after_alloc_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(full_o) |-> $past(alloc_valid_i));

  assert_full_holds_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o && !free_fire |=> full_o);

  assert_single_match_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(lookup_oh));

  assert_hit_emits_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_i && rsp_ready_o && lookup_hit |=> $countones(out_valid_o) >= 1);

  assert_idle_when_ready_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_ready_o |-> out_valid_o == '0);

  for (genvar p = 0; p < NUM_OUT; p++) begin : g_hold
    assert_out_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      out_valid_o[p] && !out_ready_i[p] |=>
        out_valid_o[p] && $stable(out_tag_o[p]) && $stable(out_data_o[p]));
  end

  assert_full_fall_on_free_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(full_o) |-> $past(free_fire));
endmodule

bind faa_decomb_buf faa_decomb_buf_chk #(
  .N_ENTRIES(N_ENTRIES), .TAG_W(TAG_W), .DATA_W(DATA_W)
) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .alloc_valid_i (alloc_valid_i),
  .full_o        (full_o),
  .rsp_valid_i   (rsp_valid_i),
  .rsp_ready_o   (rsp_ready_o),
  .out_valid_o   (out_valid_o),
  .out_ready_i   (out_ready_i),
  .out_tag_o     (out_tag_o),
  .out_data_o    (out_data_o),
  .lookup_hit    (lookup_hit),
  .lookup_oh     (lookup_oh),
  .free_fire     (free_fire)
);

// File: tb/faa_decomb_buf_tb.sv
module faa_decomb_buf_tb;
  localparam int TAG_W  = 8;
  localparam int DATA_W = 32;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #4 clk = ~clk;

  logic              alloc_valid = 1'b0;
  logic [TAG_W-1:0]  alloc_id = '0, alloc_tf = '0, alloc_ts = '0;
  logic              alloc_pf = 1'b0, alloc_ps = 1'b0;
  logic [DATA_W-1:0] alloc_add = '0;
  logic              full;
  logic              rsp_valid = 1'b0, rsp_ready;
  logic [TAG_W-1:0]  rsp_tag = '0;
  logic              rsp_port = 1'b0;
  logic [DATA_W-1:0] rsp_data = '0;
  logic [1:0]        out_valid;
  logic [1:0]        out_ready = 2'b11;
  logic [1:0][TAG_W-1:0]  out_tag;
  logic [1:0][DATA_W-1:0] out_data;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  faa_decomb_buf u_dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .alloc_valid_i(alloc_valid), .alloc_id_i(alloc_id),
    .alloc_tag_first_i(alloc_tf), .alloc_port_first_i(alloc_pf),
    .alloc_tag_second_i(alloc_ts), .alloc_port_second_i(alloc_ps),
    .alloc_addend_i(alloc_add), .full_o(full),
    .rsp_valid_i(rsp_valid), .rsp_ready_o(rsp_ready),
    .rsp_tag_i(rsp_tag), .rsp_port_i(rsp_port), .rsp_data_i(rsp_data),
    .out_valid_o(out_valid), .out_ready_i(out_ready),
    .out_tag_o(out_tag), .out_data_o(out_data)
  );

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic chk_out(string req, int p, logic [7:0] tag, logic [31:0] data);
    chk(req, $sformatf("port%0d valid", p), 32'(out_valid[p]), 32'd1);
    chk(req, $sformatf("port%0d tag", p), 32'(out_tag[p]), 32'(tag));
    chk(req, $sformatf("port%0d data", p), out_data[p], data);
  endtask

  task automatic set_alloc(logic [7:0] id, logic [7:0] tf, logic pf,
                           logic [7:0] ts, logic ps, logic [31:0] add);
    alloc_valid = 1'b1; alloc_id = id; alloc_tf = tf; alloc_pf = pf;
    alloc_ts = ts; alloc_ps = ps; alloc_add = add;
  endtask

  task automatic do_alloc(logic [7:0] id, logic [7:0] tf, logic pf,
                          logic [7:0] ts, logic ps, logic [31:0] add);
    set_alloc(id, tf, pf, ts, ps, add);
    @(negedge clk);
    alloc_valid = 1'b0;
  endtask

  task automatic send_rsp(logic [7:0] tag, logic port, logic [31:0] data);
    while (!rsp_ready) @(negedge clk);
    rsp_valid = 1'b1; rsp_tag = tag; rsp_port = port; rsp_data = data;
    @(negedge clk);
    rsp_valid = 1'b0;
  endtask

  task automatic test_reset;
    chk("R1", "full_o", 32'(full), 32'd0);
    chk("R1", "out_valid", 32'(out_valid), 32'd0);
    chk("R1", "rsp_ready", 32'(rsp_ready), 32'd1);
  endtask

  // R7 same port ordering, R4 split values
  task automatic test_same_port;
    do_alloc(8'h01, 8'hA1, 1'b0, 8'hB1, 1'b0, 32'd5);
    send_rsp(8'h01, 1'b1, 32'd100);
    chk_out("R7", 0, 8'hA1, 32'd100);
    chk("R7", "port1 idle", 32'(out_valid[1]), 32'd0);
    @(negedge clk);
    chk_out("R4", 0, 8'hB1, 32'd105);
    @(negedge clk);
    chk("R10", "drained", 32'(out_valid), 32'd0);
  endtask

  // R8 both ports same cycle, R5 wrap
  task automatic test_diff_port_wrap;
    do_alloc(8'h02, 8'hA2, 1'b1, 8'hB2, 1'b0, 32'h20);
    send_rsp(8'h02, 1'b0, 32'hFFFF_FFF0);
    chk_out("R8", 1, 8'hA2, 32'hFFFF_FFF0);
    chk_out("R5", 0, 8'hB2, 32'h0000_0010);
    @(negedge clk);
  endtask

  // R4 with addend zero (load)
  task automatic test_load;
    do_alloc(8'h09, 8'hA9, 1'b0, 8'hB9, 1'b1, 32'd0);
    send_rsp(8'h09, 1'b0, 32'hCAFE);
    chk_out("R4", 0, 8'hA9, 32'hCAFE);
    chk_out("R4", 1, 8'hB9, 32'hCAFE);
    @(negedge clk);
  endtask

  // R6 miss pass-through, R10 freed tag misses
  task automatic test_miss;
    send_rsp(8'h77, 1'b1, 32'h1234);
    chk_out("R6", 1, 8'h77, 32'h1234);
    chk("R6", "port0 idle", 32'(out_valid[0]), 32'd0);
    @(negedge clk);
    send_rsp(8'h01, 1'b0, 32'd42);
    chk_out("R10", 0, 8'h01, 32'd42);
    chk("R10", "port1 idle", 32'(out_valid[1]), 32'd0);
    @(negedge clk);
  endtask

  // R9 backpressure
  task automatic test_backpressure;
    do_alloc(8'h05, 8'hA5, 1'b0, 8'hB5, 1'b1, 32'd3);
    out_ready = 2'b00;
    send_rsp(8'h05, 1'b0, 32'd200);
    chk("R9", "both valid", 32'(out_valid), 32'd3);
    chk("R9", "rsp_ready low", 32'(rsp_ready), 32'd0);
    repeat (2) @(negedge clk);
    chk_out("R9", 0, 8'hA5, 32'd200);
    chk_out("R9", 1, 8'hB5, 32'd203);
    out_ready = 2'b01;
    @(negedge clk);
    chk("R9", "port0 taken", 32'(out_valid[0]), 32'd0);
    chk_out("R9", 1, 8'hB5, 32'd203);
    chk("R9", "rsp_ready still low", 32'(rsp_ready), 32'd0);
    out_ready = 2'b11;
    @(negedge clk);
    chk("R9", "all taken", 32'(out_valid), 32'd0);
    chk("R9", "rsp_ready back", 32'(rsp_ready), 32'd1);
  endtask

  // R11 alloc and lookup in the same cycle
  task automatic test_same_cycle;
    do_alloc(8'h03, 8'hA3, 1'b0, 8'hB3, 1'b1, 32'd10);
    set_alloc(8'h04, 8'hA4, 1'b1, 8'hB4, 1'b0, 32'd1);
    rsp_valid = 1'b1; rsp_tag = 8'h03; rsp_port = 1'b0; rsp_data = 32'd7;
    @(negedge clk);
    alloc_valid = 1'b0; rsp_valid = 1'b0;
    chk_out("R11", 0, 8'hA3, 32'd7);
    chk_out("R11", 1, 8'hB3, 32'd17);
    @(negedge clk);
    send_rsp(8'h04, 1'b0, 32'd9);
    chk_out("R11", 1, 8'hA4, 32'd9);
    chk_out("R11", 0, 8'hB4, 32'd10);
    @(negedge clk);
  endtask

  // R2 fill, R3 overflow ignored, R10 free, R12 realloc next cycle
  task automatic test_fill;
    for (int i = 0; i < 16; i++) begin
      chk("R2", $sformatf("not full before %0d", i), 32'(full), 32'd0);
      set_alloc(8'(8'h20 + i), 8'(8'h80 + i), 1'b0, 8'(8'h90 + i), 1'b1, 32'(i + 1));
      @(negedge clk);
    end
    alloc_valid = 1'b0;
    chk("R2", "full after 16", 32'(full), 32'd1);
    do_alloc(8'h55, 8'hEE, 1'b0, 8'hEF, 1'b0, 32'd1);
    chk("R3", "still full", 32'(full), 32'd1);
    send_rsp(8'h55, 1'b1, 32'hABCD);
    chk_out("R3", 1, 8'h55, 32'hABCD);
    chk("R3", "port0 idle", 32'(out_valid[0]), 32'd0);
    @(negedge clk);
    send_rsp(8'h20, 1'b0, 32'd1000);
    chk_out("R4", 0, 8'h80, 32'd1000);
    chk_out("R4", 1, 8'h90, 32'd1001);
    chk("R10", "full before last accept", 32'(full), 32'd1);
    @(negedge clk);
    chk("R10", "full fell", 32'(full), 32'd0);
    do_alloc(8'h66, 8'hC6, 1'b1, 8'hD6, 1'b1, 32'd7);
    chk("R12", "full again", 32'(full), 32'd1);
    send_rsp(8'h66, 1'b0, 32'd50);
    chk_out("R12", 1, 8'hC6, 32'd50);
    @(negedge clk);
    chk_out("R12", 1, 8'hD6, 32'd57);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    test_reset;
    rst_ni = 1'b1;
    @(negedge clk);
    test_reset;
    test_same_port;
    test_diff_port_wrap;
    test_load;
    test_miss;
    test_backpressure;
    test_same_cycle;
    test_fill;
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule